// File: doc/BRIEF.md
# Masked Register Spill and Fill Sequencer

This block moves an arbitrary, possibly scattered, subset of a 64-entry register file to or from memory in one operation. A 64-bit selection mask picks the registers: bit n set means register n takes part. The set does not need to be contiguous and need not be known before run time. A base address points at a save area laid out as a full register dump, one 8-byte slot per register. Each register therefore has a fixed slot, whichever other registers are chosen.

A request is given by pulsing start with a direction (spill to memory or fill from memory), the mask and the base address. The sequencer then visits the chosen registers from the lowest index up. For each one it issues a single memory transaction on a valid/ready port. For a spill it reads the register file and writes memory. For a fill it reads memory and writes the register file in the handshake cycle. Unselected registers cost no cycles. Register 0 is hardwired, so a fill never writes it. A one-cycle done pulse ends every request.

Top module: `regmask_xfer`

## Requirements
- R1: In spill mode (`mode_i` = 0), each selected register n produces exactly one memory transaction. The transaction has `mem_we_o` = 1, `mem_addr_o` = base + 8*n and `mem_wdata_o` equal to register n's contents.
- R2: In fill mode (`mode_i` = 1), each selected register n except 0 produces one transaction with `mem_we_o` = 0 and `mem_addr_o` = base + 8*n. In the handshake cycle, `rf_we_o` pulses with `rf_waddr_o` = n and `rf_wdata_o` = `mem_rdata_i`. `rf_we_o` is never high outside a fill handshake.
- R3: Registers whose mask bit is 0 see no memory transaction and no register-file write. Their memory slots and register contents are left unchanged.
- R4: Transactions occur in strictly ascending register index order.
- R5: In fill mode, mask bit 0 is disregarded. Register 0 is never written and is never fetched.
- R6: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_valid_o` stays high and `mem_addr_o` and `mem_we_o` hold their values.
- R7: With `mem_ready_i` held high, k selected registers complete in k consecutive cycles. `done_o` is high in the (k+1)-th cycle after the start edge, however far apart the selected bits lie.
- R8: A request with no effective selected register (an all-zero mask, or a fill whose only set bit is bit 0) raises `done_o` in the first cycle after start, with no memory transaction.
- R9: `done_o` is a single-cycle pulse. `busy_o` is high from the cycle after an accepted start until the last handshake, and `mem_valid_o` is high only while `busy_o` is high.
- R10: `start_i` is ignored while a request is in progress or its done pulse is showing. Mode, mask and base are captured only at an accepted start.
- R11: After reset, `busy_o`, `done_o`, `mem_valid_o` and `rf_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted when idle |
| mode_i | input | 1 | 0 = spill registers to memory, 1 = fill registers from memory |
| mask_i | input | 64 | Register selection, bit n selects register n |
| base_i | input | 32 | Byte address of the save area |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rf_raddr_o | output | 6 | Register-file read index |
| rf_rdata_i | input | 64 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 6 | Register-file write index |
| rf_wdata_o | output | 64 | Register-file write data |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the slot |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, valid with `mem_ready_i` |

## Verification
The bench aims at masks whose set bits are far apart, including bits 0 and 63. A design that spent a cycle per skipped index, or dropped an end bit, would miss the exact done cycle or leave the scoreboard queue unbalanced. Fill requests that include bit 0, or consist only of it, expose a sequencer that writes the hardwired register or still issues a fetch for it. Random ready stalls catch an address that moves before acceptance. A start raised mid-request with a different mask and mode catches a sequencer that re-latches its operands. An all-zero mask catches one that hangs or emits a stray transaction.

// File: rtl/regmask_pkg.sv
package regmask_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } xfer_state_e;

  typedef enum logic {
    XFER_SPILL = 1'b0,
    XFER_FILL  = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/regmask_pick.sv
// Lowest-set-bit finder: one-hot grant plus binary index.
module regmask_pick #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i]  = vec_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | vec_i[i];
  end

  assign found_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/regmask_agu.sv
// Slot address: base + index * SLOT_BYTES.
module regmask_agu #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 6,
  parameter int SLOT_BYTES = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int SHIFT = $clog2(SLOT_BYTES);

  logic [ADDR_W-1:0] offset;

  assign offset = {{(ADDR_W-IDX_W){1'b0}}, idx_i} << SHIFT;
  assign addr_o = base_i + offset;
endmodule

// File: rtl/regmask_xfer.sv
module regmask_xfer
  import regmask_pkg::*;
#(
  parameter int NREG       = 64,
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 32,
  parameter int SLOT_BYTES = 8,
  localparam int IDX_W     = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [NREG-1:0]   mask_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  xfer_state_e       state_q;
  xfer_mode_e        mode_q;
  logic [NREG-1:0]   pend_q;
  logic [ADDR_W-1:0] base_q;

  logic [NREG-1:0]   eff_mask;
  logic [NREG-1:0]   grant;
  logic [NREG-1:0]   pend_left;
  logic [IDX_W-1:0]  cur_idx;
  logic              found;
  logic              run;
  logic              hs;

  // Fill never targets the hardwired register 0.
  assign eff_mask = mask_i & {{(NREG-1){1'b1}}, ~mode_i};

  regmask_pick #(.N(NREG), .IDX_W(IDX_W)) u_pick (
    .vec_i  (pend_q),
    .grant_o(grant),
    .idx_o  (cur_idx),
    .found_o(found)
  );

  regmask_agu #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SLOT_BYTES(SLOT_BYTES)) u_agu (
    .base_i(base_q),
    .idx_i (cur_idx),
    .addr_o(mem_addr_o)
  );

  assign run       = (state_q == ST_RUN);
  assign hs        = run & mem_ready_i;
  assign pend_left = pend_q & ~grant;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= XFER_SPILL;
      pend_q  <= '0;
      base_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q  <= xfer_mode_e'(mode_i);
            base_q  <= base_i;
            pend_q  <= eff_mask;
            state_q <= (|eff_mask) ? ST_RUN : ST_DONE;
          end
        end
        ST_RUN: begin
          if (hs) begin
            pend_q <= pend_left;
            if (pend_left == '0) state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = run;
  assign done_o      = (state_q == ST_DONE);
  assign mem_valid_o = run;
  assign mem_we_o    = run & (mode_q == XFER_SPILL);
  assign mem_wdata_o = rf_rdata_i;
  assign rf_raddr_o  = cur_idx;
  assign rf_we_o     = hs & (mode_q == XFER_FILL);
  assign rf_waddr_o  = cur_idx;
  assign rf_wdata_o  = mem_rdata_i;

  // Assertions
  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)))
    else $error("p_stall_hold_r6");

  p_ascending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_ready_i) |=> (!mem_valid_o || (rf_raddr_o > $past(rf_raddr_o))))
    else $error("p_ascending_r4");

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("p_done_pulse_r9");

  p_valid_in_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> busy_o)
    else $error("p_valid_in_busy_r9");

  p_no_r0_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_waddr_o != '0))
    else $error("p_no_r0_fill_r5");

  p_fill_on_hs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (mem_valid_o && mem_ready_i && !mem_we_o))
    else $error("p_fill_on_hs_r2");

  p_run_has_work_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (found && $onehot0(grant)))
    else $error("p_run_has_work_r3");

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(done_o)) |=> (busy_o || done_o))
    else $error("p_start_ignored_r10");
endmodule

// File: tb/regmask_xfer_test.sv
module regmask_xfer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 64;
  localparam int DW   = 64;
  localparam int AW   = 32;
  localparam int IW   = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic [63:0]   mask = '0;
  logic [AW-1:0] base = '0;
  logic          busy, done;
  logic [IW-1:0] rf_raddr, rf_waddr;
  logic [DW-1:0] rf_rdata, rf_wdata;
  logic          rf_we;
  logic          mem_valid, mem_we;
  logic          mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic [DW-1:0] rf  [NREG];
  logic [DW-1:0] mem [NREG];
  logic [DW-1:0] exp_rf  [NREG];
  logic [DW-1:0] exp_mem [NREG];

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } item_t;
  item_t exp_q[$];

  int  checks = 0;
  int  fails  = 0;
  bit  ready_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit  stalled = 1'b0;
  logic [AW-1:0] stall_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[8:3]];

  regmask_xfer uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .mask_i(mask), .base_i(base), .busy_o(busy), .done_o(done),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Ready pattern driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready = ready_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  // Monitor: scoreboard pop, memory and register-file models
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled && mem_valid)
        check(mem_addr == stall_addr, "R6", "address moved under stall", mem_addr, stall_addr);
      stalled = mem_valid && !mem_ready;
      stall_addr = mem_addr;
      if (rf_we) begin
        check(mem_valid && mem_ready && !mem_we, "R2", "rf write outside fill handshake", 64'(rf_we), 64'(0));
        check(rf_waddr != 0, "R5", "register 0 written", 64'(rf_waddr), 64'(1));
        rf[rf_waddr] = rf_wdata;
      end
      if (mem_valid && mem_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected transaction", 64'(mem_addr), 64'(0));
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(mem_we == e.we, "R1/R2", "direction", 64'(mem_we), 64'(e.we));
          check(mem_addr == e.addr, "R4", "slot address/order", 64'(mem_addr), 64'(e.addr));
          if (e.we) check(mem_wdata == e.data, "R1", "spill data", mem_wdata, e.data);
          else      check(rf_wdata == e.data && rf_waddr == e.addr[8:3], "R2", "fill data", rf_wdata, e.data);
        end
        if (mem_we) mem[mem_addr[8:3]] = mem_wdata;
      end
    end
  end

  // Driver: push expectations, fire start, watch completion
  task automatic do_op(input logic m, input logic [63:0] msk, input logic [AW-1:0] b,
                       input bit poke, input bit timed);
    int k = 0;
    int cyc = 0;
    bit seen = 1'b0;
    for (int n = 0; n < NREG; n++) begin
      exp_rf[n]  = rf[n];
      exp_mem[n] = mem[n];
    end
    for (int n = 0; n < NREG; n++) begin
      if (msk[n] && !(m && n == 0)) begin
        item_t it;
        it.we   = ~m;
        it.addr = b + AW'(8 * n);
        it.data = m ? mem[n] : rf[n];
        exp_q.push_back(it);
        if (m) exp_rf[n] = mem[n];
        else   exp_mem[n] = rf[n];
        k++;
      end
    end
    @(posedge clk); #1;
    start = 1'b1; mode = m; mask = msk; base = b;
    @(posedge clk); #1;
    start = 1'b0; mask = ~msk; base = b ^ 32'h0000_4000; mode = ~m;
    while (!seen && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) check(busy == (k > 0), "R9", "busy after start", 64'(busy), 64'(k > 0));
      if (cyc == 1 && k > 0) check(!done, "R9", "early done", 64'(done), 64'(0));
      if (poke && cyc == 2) begin
        start = 1'b1; mask = '1; mode = ~m; // R10: must be ignored
      end
      if (poke && cyc == 3) start = 1'b0;
      if (done) seen = 1'b1;
    end
    check(seen, "R9", "done never seen", 64'(seen), 64'(1));
    if (timed) check(cyc == k + 1, (k == 0) ? "R8" : "R7", "done cycle", 64'(cyc), 64'(k + 1));
    @(negedge clk);
    check(!done && !busy, "R9", "done not single pulse / busy stuck", {62'd0, done, busy}, 64'(0));
    check(exp_q.size() == 0, "R3", "missing transactions", 64'(exp_q.size()), 64'(0));
    for (int n = 0; n < NREG; n++) begin
      if (rf[n] !== exp_rf[n])   check(1'b0, "R2", $sformatf("rf[%0d]", n), rf[n], exp_rf[n]);
      if (mem[n] !== exp_mem[n]) check(1'b0, "R1", $sformatf("mem[%0d]", n), mem[n], exp_mem[n]);
    end
    checks++;
    repeat (3) begin
      @(negedge clk);
      check(!done && !busy, "R10", "activity after completion", {62'd0, done, busy}, 64'(0));
    end
  endtask

  initial begin
    for (int n = 0; n < NREG; n++) begin
      rf[n]  = {32'hC0DE_0000 | 32'(n), 32'(n * 7 + 3)};
      mem[n] = {32'hBEEF_0000 | 32'(n), 32'(n * 13 + 1)};
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!busy && !done && !mem_valid && !rf_we, "R11", "reset outputs",
          {60'd0, busy, done, mem_valid, rf_we}, 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_valid && !rf_we, "R11", "idle after reset",
          {60'd0, busy, done, mem_valid, rf_we}, 64'(0));

    // R1 R7: scattered spill including both end bits
    do_op(1'b0, 64'h8000_0000_0001_0025, 32'h0000_1000, 1'b0, 1'b1);
    // R2 R5: scattered fill with bit 0 set
    do_op(1'b1, 64'h4000_0100_0800_0003, 32'h0000_2000, 1'b0, 1'b1);
    // R8: empty mask
    do_op(1'b0, 64'h0, 32'h0000_1000, 1'b0, 1'b1);
    // R8 R5: fill with only bit 0
    do_op(1'b1, 64'h1, 32'h0000_1000, 1'b0, 1'b1);
    // R7: single top bit
    do_op(1'b0, 64'h8000_0000_0000_0000, 32'h0000_3000, 1'b0, 1'b1);
    // R6 R10: full spill under random stalls, start poked mid-request
    ready_rand = 1'b1;
    for (int n = 0; n < NREG; n++) rf[n] = rf[n] ^ 64'h5555_0000_0000_0000;
    do_op(1'b0, '1, 32'h0000_4000, 1'b1, 1'b0);
    // R2 R5 R6: full fill under stalls
    for (int n = 0; n < NREG; n++) mem[n] = ~mem[n];
    do_op(1'b1, '1, 32'h0000_4000, 1'b1, 1'b0);
    // R3 R4: alternating pattern fill, stalled
    for (int n = 0; n < NREG; n++) mem[n] = mem[n] + 64'(n);
    do_op(1'b1, 64'hAAAA_5555_F00F_0FF0, 32'h0000_0200, 1'b0, 1'b0);
    ready_rand = 1'b0;
    do_op(1'b0, 64'h0000_0F00_0000_0100, 32'h0000_0400, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule